// File: doc/BRIEF.md
# Generation-Tagged Context Entry Cache

This block keeps one cached translation context entry per device slot of a single PCI bus, for an IOMMU. There are 2^DEVFN_W slots, one per device/function number. Each slot stores the entry together with a generation stamp. A slot counts as valid only while its stamp equals a global generation counter. A fill port writes an entry into a slot and stamps it with the current generation. A lookup port returns hit/miss and the entry one cycle later. Fetching entries from memory and walking the root table happen outside this block.

A global invalidation does not sweep the array. It advances the global generation, so every existing stamp goes stale at once. The slot stamps are actually cleared only when the counter reaches its top value. A domain-selective invalidation behaves exactly like a global one. A device-selective invalidation clears the stamps of one slot, or of a small group of function-adjacent slots, using a 2-bit function-mask code.

The block remembers which bus number its slots belong to. A fill for a different bus takes over the cache and discards every other slot.

Top module: `ctx_gen_cache`

## Requirements
- R1: After reset, every lookup misses until a slot is filled.
- R2: `rsp_valid` is high exactly one cycle after `lk_valid`. A lookup of a slot that was filled on the same bus, with no invalidation touching it since, reports a hit and returns the filled entry.
- R3: A lookup that misses returns `rsp_hit` = 0 and `rsp_entry` = 0.
- R4: A global invalidation (`inv_op` = 2'b01) makes every previously filled slot miss. A fill made after it hits again.
- R5: A domain-selective invalidation (`inv_op` = 2'b10) has exactly the effect of a global invalidation.
- R6: A device-selective invalidation (`inv_op` = 2'b11) takes `inv_sid` = {bus[15:8], devfn[7:0]}. It clears every slot whose devfn equals the target devfn outside the ignored bits. `inv_fm` picks the ignored bits: 0 ignores none, 1 ignores bit 2, 2 ignores bits 2:1, 3 ignores bits 2:0. All other slots keep their state.
- R7: A device-selective invalidation whose bus differs from the cached bus has no effect.
- R8: The generation counter is GEN_W bits wide and starts at 1. When an invalidation would move it to 2^GEN_W-1, it becomes 1 instead and every slot stamp is cleared. An entry filled before the wrap therefore misses even after the counter returns to its old value.
- R9: A lookup hits only when its bus equals the cached bus. A fill with a different bus makes that bus the cached bus and drops every other slot.
- R10: A lookup or fill in the same cycle as an invalidation sees the post-invalidation state. A fill in the same cycle as a lookup of the same slot is visible to that lookup.
- R11: `inv_op` = 2'b00 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_bus | input | BUS_W | Lookup bus number |
| lk_devfn | input | DEVFN_W | Lookup device/function |
| fill_valid | input | 1 | Fill request |
| fill_bus | input | BUS_W | Fill bus number |
| fill_devfn | input | DEVFN_W | Fill device/function |
| fill_entry | input | ENTRY_W | Context entry to store |
| inv_op | input | 2 | 00 none, 01 global, 10 domain, 11 device |
| inv_sid | input | BUS_W+DEVFN_W | Source ID {bus, devfn} for device-selective invalidation |
| inv_fm | input | 2 | Function-mask code for device-selective invalidation |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_entry | output | ENTRY_W | Entry on hit, zero on miss |

## Verification
The bench builds the block with GEN_W = 3 and ENTRY_W = 16, and leaves the bus and devfn widths at 8. The small generation counter reaches its top value after six invalidations, so the wrap clear can be shown to matter: a slot stamped before the wrap is looked up once the counter is back at that same stamp. The full 256-slot devfn space keeps all four function-mask groupings distinct, and slots outside a group can be checked as untouched.

// File: rtl/ctx_gen_cache.sv
module ctx_gen_cache #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int GEN_W   = 8,
  parameter int ENTRY_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [BUS_W-1:0]         lk_bus,
  input  logic [DEVFN_W-1:0]       lk_devfn,
  input  logic                     fill_valid,
  input  logic [BUS_W-1:0]         fill_bus,
  input  logic [DEVFN_W-1:0]       fill_devfn,
  input  logic [ENTRY_W-1:0]       fill_entry,
  input  logic [1:0]               inv_op,
  input  logic [BUS_W+DEVFN_W-1:0] inv_sid,
  input  logic [1:0]               inv_fm,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [ENTRY_W-1:0]       rsp_entry
);
  localparam int SLOTS = 1 << DEVFN_W;
  localparam int SID_W = BUS_W + DEVFN_W;
  localparam logic [GEN_W-1:0] GEN_TOP = '1;
  localparam logic [1:0] OP_GLOBAL = 2'b01, OP_DOMAIN = 2'b10, OP_DEVICE = 2'b11;

  logic [GEN_W-1:0]   cur_gen;
  logic [BUS_W-1:0]   bus_tag;
  logic [GEN_W-1:0]   slot_gen    [SLOTS];
  logic [GEN_W-1:0]   slot_gen_nx [SLOTS];
  logic [ENTRY_W-1:0] slot_ent    [SLOTS];
  logic [DEVFN_W-1:0] care;

  wire               bump     = (inv_op == OP_GLOBAL) || (inv_op == OP_DOMAIN);
  wire [GEN_W-1:0]   gen_inc  = cur_gen + 1'b1;
  wire               wrap     = bump && (gen_inc == GEN_TOP);
  wire [GEN_W-1:0]   gen_nx   = !bump ? cur_gen : (wrap ? GEN_W'(1) : gen_inc);
  wire               retag    = fill_valid && (fill_bus != bus_tag);
  wire [BUS_W-1:0]   tag_nx   = fill_valid ? fill_bus : bus_tag;
  wire               wipe     = wrap || retag;
  wire [BUS_W-1:0]   sid_bus  = inv_sid[SID_W-1:DEVFN_W];
  wire [DEVFN_W-1:0] sid_fn   = inv_sid[DEVFN_W-1:0];
  wire               dev_inv  = (inv_op == OP_DEVICE) && (sid_bus == bus_tag);

  always_comb begin
    case (inv_fm)
      2'd0:    care = '1;
      2'd1:    care = ~DEVFN_W'(3'b100);
      2'd2:    care = ~DEVFN_W'(3'b110);
      default: care = ~DEVFN_W'(3'b111);
    endcase
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      if (fill_valid && fill_devfn == DEVFN_W'(i))
        slot_gen_nx[i] = gen_nx;
      else if (wipe || (dev_inv && ((DEVFN_W'(i) ^ sid_fn) & care) == '0))
        slot_gen_nx[i] = '0;
      else
        slot_gen_nx[i] = slot_gen[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_gen <= GEN_W'(1);
      bus_tag <= '0;
      for (int i = 0; i < SLOTS; i++) slot_gen[i] <= '0;
    end else begin
      cur_gen  <= gen_nx;
      bus_tag  <= tag_nx;
      slot_gen <= slot_gen_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) slot_ent[fill_devfn] <= fill_entry;
  end

  wire               same_slot = fill_valid && (fill_devfn == lk_devfn);
  wire [ENTRY_W-1:0] lk_view   = same_slot ? fill_entry : slot_ent[lk_devfn];
  wire               hit_nx    = lk_valid && (lk_bus == tag_nx) &&
                                 (slot_gen_nx[lk_devfn] == gen_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_entry <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_nx;
      rsp_entry <= hit_nx ? lk_view : '0;
    end
  end
endmodule

// File: rtl/ctx_gen_cache_chk.sv
module ctx_gen_cache_chk #(
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int GEN_W   = 8,
  parameter int ENTRY_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [BUS_W-1:0]   lk_bus,
  input logic [DEVFN_W-1:0] lk_devfn,
  input logic               fill_valid,
  input logic [BUS_W-1:0]   fill_bus,
  input logic [DEVFN_W-1:0] fill_devfn,
  input logic [ENTRY_W-1:0] fill_entry,
  input logic [1:0]         inv_op,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [ENTRY_W-1:0] rsp_entry,
  input logic [GEN_W-1:0]   cur_gen
);
  localparam logic [GEN_W-1:0] GEN_TOP = '1;

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_entry == '0);
  // R8
  gen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_gen != '0) && (cur_gen != GEN_TOP));
  // R4
  gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((inv_op == 2'b01 || inv_op == 2'b10) && cur_gen != GEN_TOP - 1'b1)
      |=> cur_gen == $past(cur_gen) + 1'b1);
  // R8
  gen_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((inv_op == 2'b01 || inv_op == 2'b10) && cur_gen == GEN_TOP - 1'b1)
      |=> cur_gen == GEN_W'(1));
  // R11
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_op == 2'b00 || inv_op == 2'b11) |=> $stable(cur_gen));
  // R10
  fill_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && lk_valid && lk_bus == fill_bus && lk_devfn == fill_devfn)
      |=> rsp_hit && rsp_entry == $past(fill_entry));
  // R2
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

bind ctx_gen_cache ctx_gen_cache_chk #(
  .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .GEN_W(GEN_W), .ENTRY_W(ENTRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_bus(lk_bus),
  .lk_devfn(lk_devfn), .fill_valid(fill_valid), .fill_bus(fill_bus),
  .fill_devfn(fill_devfn), .fill_entry(fill_entry), .inv_op(inv_op),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_entry(rsp_entry),
  .cur_gen(cur_gen)
);

// File: tb/sim_ctx_gen_cache.sv
module sim_ctx_gen_cache;
  localparam int BW = 8, FW = 8, GW = 3, EW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0;
  logic [BW-1:0] lk_bus = '0, fill_bus = '0;
  logic [FW-1:0] lk_devfn = '0, fill_devfn = '0;
  logic [EW-1:0] fill_entry = '0;
  logic [1:0] inv_op = 2'b00, inv_fm = 2'b00;
  logic [BW+FW-1:0] inv_sid = '0;
  logic rsp_valid, rsp_hit;
  logic [EW-1:0] rsp_entry;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  bit q_hit[$];
  logic [EW-1:0] q_ent[$];
  string q_req[$];

  always #5 clk = ~clk;

  ctx_gen_cache #(.BUS_W(BW), .DEVFN_W(FW), .GEN_W(GW), .ENTRY_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_bus(lk_bus),
    .lk_devfn(lk_devfn), .fill_valid(fill_valid), .fill_bus(fill_bus),
    .fill_devfn(fill_devfn), .fill_entry(fill_entry), .inv_op(inv_op),
    .inv_sid(inv_sid), .inv_fm(inv_fm), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_entry(rsp_entry));

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_hit.size() == 0) check(1'b0, "R2 unexpected response", 32'(rsp_valid), 32'h0);
      else begin
        automatic bit eh = q_hit.pop_front();
        automatic logic [EW-1:0] ee = q_ent.pop_front();
        automatic string r = q_req.pop_front();
        check({rsp_hit, rsp_entry} === {eh, (eh ? ee : EW'(0))}, r,
              32'({rsp_hit, rsp_entry}), 32'({eh, (eh ? ee : EW'(0))}));
      end
    end
  end

  task automatic step();
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0; inv_op = 2'b00;
  endtask

  task automatic put_look(logic [7:0] b, logic [7:0] f, bit eh, logic [EW-1:0] ee, string r);
    lk_valid = 1'b1; lk_bus = b; lk_devfn = f;
    q_hit.push_back(eh); q_ent.push_back(ee); q_req.push_back(r);
  endtask

  task automatic look(logic [7:0] b, logic [7:0] f, bit eh, logic [EW-1:0] ee, string r);
    put_look(b, f, eh, ee, r); step();
  endtask

  task automatic put_fill(logic [7:0] b, logic [7:0] f, logic [EW-1:0] e);
    fill_valid = 1'b1; fill_bus = b; fill_devfn = f; fill_entry = e;
  endtask

  task automatic fill(logic [7:0] b, logic [7:0] f, logic [EW-1:0] e);
    put_fill(b, f, e); step();
  endtask

  task automatic inv(logic [1:0] op, logic [15:0] sid, logic [1:0] fm);
    inv_op = op; inv_sid = sid; inv_fm = fm; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_hit == 1'b0, "R1 reset outputs", 32'({rsp_valid, rsp_hit}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    look(8'h00, 8'h00, 1'b0, '0, "R1 miss after reset");
    look(8'h00, 8'h05, 1'b0, '0, "R1 miss after reset");
    step();
    check(rsp_valid == 1'b0, "R2 no response without lookup", 32'(rsp_valid), 32'h0);

    fill(8'h03, 8'h10, 16'hA010);
    look(8'h03, 8'h10, 1'b1, 16'hA010, "R2 fill then hit");
    look(8'h03, 8'h11, 1'b0, '0, "R3 unfilled slot misses");
    look(8'h04, 8'h10, 1'b0, '0, "R9 wrong bus misses");

    for (int i = 0; i < 16; i++) fill(8'h03, 8'(8'h20 + i), 16'(16'h0200 + i));
    inv(2'b11, 16'h0322, 2'd0);
    look(8'h03, 8'h22, 1'b0, '0, "R6 code0 target cleared");
    look(8'h03, 8'h23, 1'b1, 16'h0203, "R6 code0 neighbour kept");
    look(8'h03, 8'h26, 1'b1, 16'h0206, "R6 code0 bit2 peer kept");
    inv(2'b11, 16'h0321, 2'd1);
    look(8'h03, 8'h21, 1'b0, '0, "R6 code1 target cleared");
    look(8'h03, 8'h25, 1'b0, '0, "R6 code1 bit2 peer cleared");
    look(8'h03, 8'h20, 1'b1, 16'h0200, "R6 code1 other kept");
    inv(2'b11, 16'h0320, 2'd2);
    look(8'h03, 8'h24, 1'b0, '0, "R6 code2 peer cleared");
    look(8'h03, 8'h26, 1'b0, '0, "R6 code2 peer cleared");
    look(8'h03, 8'h23, 1'b1, 16'h0203, "R6 code2 odd kept");
    look(8'h03, 8'h27, 1'b1, 16'h0207, "R6 code2 odd kept");
    inv(2'b11, 16'h032B, 2'd3);
    look(8'h03, 8'h2F, 1'b0, '0, "R6 code3 group cleared");
    look(8'h03, 8'h28, 1'b0, '0, "R6 code3 group cleared");
    look(8'h03, 8'h27, 1'b1, 16'h0207, "R6 code3 outside kept");
    look(8'h03, 8'h10, 1'b1, 16'hA010, "R6 code3 far slot kept");
    inv(2'b11, 16'h0510, 2'd3);
    look(8'h03, 8'h10, 1'b1, 16'hA010, "R7 other bus ignored");
    inv(2'b00, 16'h0310, 2'd3);
    look(8'h03, 8'h10, 1'b1, 16'hA010, "R11 no-op keeps slot");

    inv(2'b01, 16'h0000, 2'd0);                       // gen 2
    look(8'h03, 8'h10, 1'b0, '0, "R4 global clears");
    look(8'h03, 8'h27, 1'b0, '0, "R4 global clears");
    fill(8'h03, 8'h10, 16'hB010);
    look(8'h03, 8'h10, 1'b1, 16'hB010, "R4 refill hits");
    inv(2'b10, 16'h0310, 2'd0);                       // gen 3
    look(8'h03, 8'h10, 1'b0, '0, "R5 domain clears");

    fill(8'h03, 8'h40, 16'hC040);                     // stamped 3
    inv(2'b01, '0, 2'd0); inv(2'b01, '0, 2'd0); inv(2'b01, '0, 2'd0);  // 4,5,6
    fill(8'h03, 8'h41, 16'hD041);                     // stamped 6
    look(8'h03, 8'h41, 1'b1, 16'hD041, "R8 before wrap hits");
    inv(2'b01, '0, 2'd0);                             // wrap to 1
    fill(8'h03, 8'h42, 16'hE042);
    look(8'h03, 8'h42, 1'b1, 16'hE042, "R8 after wrap fill hits");
    inv(2'b01, '0, 2'd0); inv(2'b01, '0, 2'd0);       // 2,3
    look(8'h03, 8'h40, 1'b0, '0, "R8 stale stamp cleared by wrap");
    fill(8'h03, 8'h40, 16'hC140);
    look(8'h03, 8'h40, 1'b1, 16'hC140, "R8 refill after wrap");

    put_look(8'h03, 8'h40, 1'b0, '0, "R10 lookup sees same-cycle global");
    inv(2'b01, '0, 2'd0);
    put_fill(8'h03, 8'h50, 16'hF050);
    put_look(8'h03, 8'h50, 1'b1, 16'hF050, "R10 fill with global and lookup");
    inv(2'b01, '0, 2'd0);
    look(8'h03, 8'h50, 1'b1, 16'hF050, "R10 fill survives same-cycle global");
    put_fill(8'h03, 8'h51, 16'hF051);
    inv(2'b11, 16'h0351, 2'd0);
    look(8'h03, 8'h51, 1'b1, 16'hF051, "R10 fill survives same-cycle device inv");

    fill(8'h06, 8'h60, 16'h6060);
    look(8'h06, 8'h60, 1'b1, 16'h6060, "R9 retag fill hits");
    look(8'h06, 8'h50, 1'b0, '0, "R9 retag drops others");
    look(8'h03, 8'h50, 1'b0, '0, "R9 old bus misses");

    step(); step();
    check(q_hit.size() == 0, "R2 responses outstanding", 32'(q_hit.size()), 32'h0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule